// File: doc/BRIEF.md
# Quad DAC Command and Register Bank

This block turns already-received serial bus bytes into register operations for four DAC channels. Every channel keeps a staging register, a live code register and a two-bit power-down mode. The byte receiver in front of the block hands over each byte together with its position in the current command. It also gives a strobe that marks the acknowledge slot of that byte, and an abort pulse when the transfer is cut short. The block's outputs are the four live codes, the four modes and a pair of read-back bytes for one selected channel.

A command starts with a byte that holds a 4-bit operation code in its upper nibble and the top four data bits in its lower nibble. Most operations then take a second byte that carries the low six data bits and two filler bits. Depending on the code, the new value goes to one channel or to all channels. It goes to the staging register, the live register or both. The other channels may have their staging values copied to their live registers at the same instant. Some codes take only one byte: a pure transfer, a power-down setup, or the selection of a channel for read-back.

Top module: `qdac_cmd_bank`

## Requirements
- R1: After reset, every staging and live code is 0, every channel mode is 2'b11 (100 kΩ to ground), and both read-back bytes are 0.
- R2: A command changes no code and no mode at the strobe of its first byte (rx_idx=0). Operation code is rx_byte[7:4], data bits 9..6 are rx_byte[3:0], and data bits 5..0 are rx_byte[7:2] of the second byte (rx_idx=1). The second byte's bits [1:0] are ignored.
- R3: Codes 0..3 select channel 0..3. The 10-bit value goes into that channel's staging and live registers. Each other channel copies its staging value to its live register. All of this happens at the second-byte strobe.
- R4: Codes 4..7 write the value into the staging register of channel 0..3 only. No live code changes.
- R5: Codes 8..11 write the value into the staging register of channel 0..3. Then all four staging values move to the live registers, so the addressed live code equals the new value.
- R6: Code 12 writes the value into every staging and every live register.
- R7: Code 13 writes the value into every staging register. The live codes stay as they were.
- R8: Code 14 copies all staging values to the live registers at the strobe of its single byte and ignores rx_byte[3:0]. A byte with rx_idx=1 that follows it has no effect.
- R9: Code 15 with rx_byte[3:0]=0 is a power-down setup. The next byte's bit 2+k selects channel k, and that byte's bits [1:0] become the new mode of every selected channel. Bits [7:6] of that byte are ignored.
- R10: The mode encoding is 00 powered, 01 floating, 10 1 kΩ and 11 100 kΩ. A mode change never alters a staging or live code, so going back to 00 restores the previous output code.
- R11: Code 15 with rx_byte[3:0] = 0001, 0010, 0100 or 1000 selects channel 0, 1, 2 or 3 for read-back. Then rd_hi = {2'b00, mode, code[9:6]} and rd_lo = {code[5:0], 2'b00}, using the live code.
- R12: An abort pulse drops any half-finished command, so a later rx_idx=1 byte is ignored. It also clears the read-back selection, so both read bytes become 0.
- R13: Any other code-15 pattern, and any first byte that is not a read-back select, changes no code or mode and leaves both read bytes at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_stb | input | 1 | One-cycle strobe at the acknowledge slot of a received byte |
| rx_idx | input | 1 | Byte position within the command: 0 for the first byte, 1 for the following byte |
| rx_byte | input | 8 | Received byte, valid with ack_stb |
| abort | input | 1 | Transfer cut short; drops pending state |
| dac_code | output | 40 | Live codes, channel k in bits [10k+9:10k] |
| pd_mode | output | 8 | Power-down modes, channel k in bits [2k+1:2k] |
| rd_hi | output | 8 | First read-back byte |
| rd_lo | output | 8 | Second read-back byte |

## Verification
The bench goes after the first-byte strobe. A design that commits early would show a half-formed code there. It sends code 14 followed by a stray data byte; a design that stays armed would overwrite a staging register. It aborts between the two bytes, and a leaky design would apply the late second byte. It also sends invalid code-15 patterns and toggles modes around stored codes. A design that treats an invalid pattern as a power-down setup, or clears codes when powering down, would show wrong codes or stale read-back bytes.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH  = 4;
  localparam int DW   = 10;
  localparam int BW   = 8;
  localparam int CW   = 4;
  localparam int PDW  = 2;
  localparam int IDXW = $clog2(NCH);
  localparam int LOW  = DW - CW;

  typedef enum logic [PDW-1:0] {
    PD_ON   = 2'b00,
    PD_HIZ  = 2'b01,
    PD_1K   = 2'b10,
    PD_100K = 2'b11
  } pd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_DATA = 2'b01,
    SQ_EXT  = 2'b10
  } seq_e;
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
(
  input  logic [CW-1:0]   code,
  input  logic [CW-1:0]   hi,
  output logic [NCH-1:0]  wr_mask,
  output logic [NCH-1:0]  xf_mask,
  output logic            is_data,
  output logic            is_imm,
  output logic            is_ext,
  output logic            is_rsel,
  output logic [IDXW-1:0] rsel_ch
);
  logic [NCH-1:0] one_ch;

  always_comb begin
    one_ch  = NCH'(1) << code[1:0];
    wr_mask = '0;
    xf_mask = '0;
    is_data = 1'b0;
    is_imm  = 1'b0;
    is_ext  = 1'b0;
    is_rsel = 1'b0;
    rsel_ch = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hi[i]) rsel_ch = IDXW'(i);
    end
    unique case (code[3:2])
      2'b00: begin wr_mask = one_ch; xf_mask = '1; is_data = 1'b1; end
      2'b01: begin wr_mask = one_ch; is_data = 1'b1; end
      2'b10: begin wr_mask = one_ch; xf_mask = '1; is_data = 1'b1; end
      default: begin
        unique case (code[1:0])
          2'b00: begin wr_mask = '1; xf_mask = '1; is_data = 1'b1; end
          2'b01: begin wr_mask = '1; is_data = 1'b1; end
          2'b10: begin xf_mask = '1; is_imm = 1'b1; end
          default: begin
            if (hi == '0)          is_ext  = 1'b1;
            else if ($onehot(hi))  is_rsel = 1'b1;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_in,
  input  logic           xfer,
  input  logic [DW-1:0]  data,
  input  logic           pd_we,
  input  logic [PDW-1:0] pd_val,
  output logic [DW-1:0]  in_q,
  output logic [DW-1:0]  dac_q,
  output logic [PDW-1:0] pd_q
);
  logic [DW-1:0]  in_d;
  logic [DW-1:0]  dac_d;
  logic [PDW-1:0] pd_d;

  always_comb begin
    in_d  = data;
    dac_d = wr_in ? data : in_q;
    pd_d  = pd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      pd_q  <= PD_100K;
    end else begin
      if (wr_in) in_q  <= in_d;
      if (xfer)  dac_q <= dac_d;
      if (pd_we) pd_q  <= pd_d;
    end
  end

  // R10: a mode write alone keeps both stored codes
  p_mode_keeps_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_we && !wr_in && !xfer) |=> ($stable(in_q) && $stable(dac_q)));
endmodule

// File: rtl/qdac_readback.sv
module qdac_readback
  import qdac_pkg::*;
(
  input  logic              sel_vld,
  input  logic [IDXW-1:0]   sel_ch,
  input  logic [NCH*DW-1:0] codes,
  input  logic [NCH*PDW-1:0] modes,
  output logic [BW-1:0]     rd_hi,
  output logic [BW-1:0]     rd_lo
);
  logic [DW-1:0]  code_sel;
  logic [PDW-1:0] mode_sel;

  always_comb begin
    code_sel = codes[sel_ch*DW +: DW];
    mode_sel = modes[sel_ch*PDW +: PDW];
    rd_hi = '0;
    rd_lo = '0;
    if (sel_vld) begin
      rd_hi = {2'b00, mode_sel, code_sel[DW-1 -: CW]};
      rd_lo = {code_sel[LOW-1:0], 2'b00};
    end
  end
endmodule

// File: rtl/qdac_cmd_bank.sv
module qdac_cmd_bank
  import qdac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ack_stb,
  input  logic                 rx_idx,
  input  logic [7:0]           rx_byte,
  input  logic                 abort,
  output logic [NCH*DW-1:0]    dac_code,
  output logic [NCH*PDW-1:0]   pd_mode,
  output logic [7:0]           rd_hi,
  output logic [7:0]           rd_lo
);
  logic rst_s0, rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_ns <= rst_s0;
    end
  end

  seq_e           st_q, st_d;
  logic [CW-1:0]  pc_q, pc_d;
  logic [CW-1:0]  ph_q, ph_d;
  logic           rv_q, rv_d;
  logic [IDXW-1:0] rc_q, rc_d;

  logic [CW-1:0]   dec_code, dec_hi;
  logic [NCH-1:0]  d_wr, d_xf;
  logic            d_data, d_imm, d_ext, d_rsel;
  logic [IDXW-1:0] d_rch;

  logic [NCH-1:0]  wr_mask, xf_mask, pd_we;
  logic [DW-1:0]   wdata;
  logic [NCH*DW-1:0] in_flat;

  assign dec_code = rx_idx ? pc_q : rx_byte[7:4];
  assign dec_hi   = rx_idx ? ph_q : rx_byte[3:0];
  assign wdata    = {ph_q, rx_byte[7:2]};

  qdac_decode u_dec (
    .code    (dec_code),
    .hi      (dec_hi),
    .wr_mask (d_wr),
    .xf_mask (d_xf),
    .is_data (d_data),
    .is_imm  (d_imm),
    .is_ext  (d_ext),
    .is_rsel (d_rsel),
    .rsel_ch (d_rch)
  );

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    ph_d    = ph_q;
    rv_d    = rv_q;
    rc_d    = rc_q;
    wr_mask = '0;
    xf_mask = '0;
    pd_we   = '0;
    if (abort) begin
      st_d = SQ_IDLE;
      rv_d = 1'b0;
    end else if (ack_stb) begin
      if (!rx_idx) begin
        st_d = SQ_IDLE;
        rv_d = 1'b0;
        pc_d = rx_byte[7:4];
        ph_d = rx_byte[3:0];
        if (d_imm) begin
          xf_mask = d_xf;
        end else if (d_ext) begin
          st_d = SQ_EXT;
        end else if (d_rsel) begin
          rv_d = 1'b1;
          rc_d = d_rch;
        end else if (d_data) begin
          st_d = SQ_DATA;
        end
      end else begin
        st_d = SQ_IDLE;
        if (st_q == SQ_DATA) begin
          wr_mask = d_wr;
          xf_mask = d_xf;
        end else if (st_q == SQ_EXT) begin
          pd_we = rx_byte[2 +: NCH];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= SQ_IDLE;
      pc_q <= '0;
      ph_q <= '0;
      rv_q <= 1'b0;
      rc_q <= '0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      if (ack_stb && !rx_idx) begin
        pc_q <= pc_d;
        ph_q <= ph_d;
      end
      if (rv_d) rc_q <= rc_d;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    qdac_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_ns),
      .wr_in  (wr_mask[k]),
      .xfer   (xf_mask[k]),
      .data   (wdata),
      .pd_we  (pd_we[k]),
      .pd_val (rx_byte[1:0]),
      .in_q   (in_flat[k*DW +: DW]),
      .dac_q  (dac_code[k*DW +: DW]),
      .pd_q   (pd_mode[k*PDW +: PDW])
    );
  end

  qdac_readback u_rb (
    .sel_vld (rv_q),
    .sel_ch  (rc_q),
    .codes   (dac_code),
    .modes   (pd_mode),
    .rd_hi   (rd_hi),
    .rd_lo   (rd_lo)
  );

  // R2: with no strobe nothing visible moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ack_stb && !abort) |=> ($stable(dac_code) && $stable(pd_mode)));

  // R9: modes change only on a second byte, never on a first byte
  p_first_no_mode_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (ack_stb && !rx_idx) |=> $stable(pd_mode));

  // R8: single-byte transfer copies the staging registers
  p_update_copy_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (ack_stb && !abort && !rx_idx && rx_byte[7:4] == 4'hE) |=> (dac_code == $past(in_flat)));

  // R12: abort blanks read-back
  p_abort_blank_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    abort |=> (rd_hi == 8'h00 && rd_lo == 8'h00));

  // R13: a first byte that is not code 15 leaves read-back at zero
  p_noread_blank_r13: assert property (@(posedge clk) disable iff (!rst_ns)
    (ack_stb && !abort && !rx_idx && rx_byte[7:4] != 4'hF) |=> (rd_hi == 8'h00 && rd_lo == 8'h00));
endmodule

// File: tb/qdac_cmd_bank_tb.sv
module qdac_cmd_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_stb = 1'b0;
  logic        rx_idx = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        abort = 1'b0;
  logic [39:0] dac_code;
  logic [7:0]  pd_mode;
  logic [7:0]  rd_hi, rd_lo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  qdac_cmd_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .rx_idx(rx_idx),
    .rx_byte(rx_byte), .abort(abort), .dac_code(dac_code),
    .pd_mode(pd_mode), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  // {two bytes, first byte, second byte}
  localparam logic [16:0] VEC [16] = '{
    {1'b1, 8'h07, 8'hF4}, {1'b1, 8'h4A, 8'h88}, {1'b1, 8'h53, 8'h30},
    {1'b1, 8'h25, 8'hFC}, {1'b1, 8'h71, 8'h04}, {1'b1, 8'h9C, 8'h40},
    {1'b1, 8'h62, 8'hA8}, {1'b0, 8'hE5, 8'h00}, {1'b1, 8'hD3, 8'h14},
    {1'b1, 8'hF0, 8'h0D}, {1'b0, 8'hF4, 8'h00}, {1'b1, 8'hC8, 8'h7C},
    {1'b1, 8'hF0, 8'h3C}, {1'b0, 8'hF8, 8'h00}, {1'b1, 8'hBF, 8'hFC},
    {1'b1, 8'h30, 8'h00}
  };

  logic [9:0] m_in [4];
  logic [9:0] m_dac [4];
  logic [1:0] m_pd [4];
  int         m_pend;
  logic [3:0] m_code, m_hi;
  logic       m_rv;
  int         m_rc;

  task automatic model_byte(input logic idx, input logic [7:0] b);
    logic [9:0] d;
    int k;
    if (!idx) begin
      m_pend = 0; m_rv = 1'b0; m_code = b[7:4]; m_hi = b[3:0];
      if (m_code == 4'hE) begin
        for (int j = 0; j < 4; j++) m_dac[j] = m_in[j];
      end else if (m_code == 4'hF) begin
        if (m_hi == 4'h0) m_pend = 2;
        else if (m_hi == 4'h1) begin m_rv = 1'b1; m_rc = 0; end
        else if (m_hi == 4'h2) begin m_rv = 1'b1; m_rc = 1; end
        else if (m_hi == 4'h4) begin m_rv = 1'b1; m_rc = 2; end
        else if (m_hi == 4'h8) begin m_rv = 1'b1; m_rc = 3; end
      end else begin
        m_pend = 1;
      end
    end else begin
      if (m_pend == 1) begin
        d = {m_hi, b[7:2]};
        k = int'(m_code[1:0]);
        if (m_code[3:2] == 2'b01) m_in[k] = d;
        else if (m_code[3:2] != 2'b11) begin
          m_in[k] = d;
          for (int j = 0; j < 4; j++) m_dac[j] = m_in[j];
        end else if (m_code[1:0] == 2'b00) begin
          for (int j = 0; j < 4; j++) begin m_in[j] = d; m_dac[j] = d; end
        end else begin
          for (int j = 0; j < 4; j++) m_in[j] = d;
        end
      end else if (m_pend == 2) begin
        for (int j = 0; j < 4; j++) if (b[2+j]) m_pd[j] = b[1:0];
      end
      m_pend = 0;
    end
  endtask

  task automatic send(input logic idx, input logic [7:0] b);
    @(negedge clk);
    rx_idx = idx; rx_byte = b; ack_stb = 1'b1;
    @(negedge clk);
    ack_stb = 1'b0;
    model_byte(idx, b);
  endtask

  task automatic do_abort();
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    m_pend = 0; m_rv = 1'b0;
  endtask

  task automatic check(input string tag);
    logic [39:0] e_dac;
    logic [7:0]  e_pd, e_hi, e_lo;
    for (int j = 0; j < 4; j++) begin
      e_dac[j*10 +: 10] = m_dac[j];
      e_pd[j*2 +: 2]    = m_pd[j];
    end
    e_hi = m_rv ? {2'b00, m_pd[m_rc], m_dac[m_rc][9:6]} : 8'h00;
    e_lo = m_rv ? {m_dac[m_rc][5:0], 2'b00} : 8'h00;
    checks++;
    if (dac_code !== e_dac || pd_mode !== e_pd || rd_hi !== e_hi || rd_lo !== e_lo) begin
      errors++;
      $display("FAIL %s: actual dac=%h pd=%h rd=%h_%h expected dac=%h pd=%h rd=%h_%h",
               tag, dac_code, pd_mode, rd_hi, rd_lo, e_dac, e_pd, e_hi, e_lo);
    end
  endtask

  function automatic string tag_of(input logic [7:0] b0);
    case (b0[7:4])
      4'h0, 4'h1, 4'h2, 4'h3: return "R3";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'h8, 4'h9, 4'hA, 4'hB: return "R5";
      4'hC: return "R6";
      4'hD: return "R7";
      4'hE: return "R8";
      default: return (b0[3:0] == 4'h0) ? "R9" : "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 4; j++) begin m_in[j] = '0; m_dac[j] = '0; m_pd[j] = 2'b11; end
    m_pend = 0; m_code = '0; m_hi = '0; m_rv = 1'b0; m_rc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset state");

    for (int i = 0; i < 16; i++) begin
      send(1'b0, VEC[i][15:8]);
      if (VEC[i][16]) send(1'b1, VEC[i][7:0]);
      check(tag_of(VEC[i][15:8]));
    end

    // R2: first byte alone commits nothing
    send(1'b0, 8'h0F);
    check("R2 first byte only");
    // R12: abort drops it, late second byte ignored
    do_abort();
    send(1'b1, 8'hFF);
    check("R12 abort then stray byte");

    // R13: invalid code-15 pattern
    send(1'b0, 8'hF1);
    check("R11 select channel 0");
    send(1'b0, 8'hF3);
    check("R13 invalid pattern");
    send(1'b1, 8'hFF);
    check("R13 no setup armed");

    // R12: abort clears read selection
    send(1'b0, 8'hF2);
    do_abort();
    check("R12 abort clears read");

    // R8: single byte transfer, stray byte ignored
    send(1'b0, 8'h47); send(1'b1, 8'h5C);
    send(1'b0, 8'hE0);
    check("R8 transfer");
    send(1'b1, 8'hAB);
    check("R8 stray byte");

    // R10: power down all then up, codes retained
    send(1'b0, 8'hF0); send(1'b1, 8'hFF);
    check("R10 all 100k");
    send(1'b0, 8'hF8);
    check("R10 readback pd bits");
    send(1'b0, 8'hF0); send(1'b1, 8'h3A);
    check("R10 mixed mode");
    send(1'b0, 8'hF0); send(1'b1, 8'hC0);
    check("R9 empty mask");
    send(1'b0, 8'hF0); send(1'b1, 8'h3C);
    check("R10 power up restores");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule